// File: doc/BRIEF.md
# DIMM Activity Throttle Limiter

This block caps how many memory commands each memory module may receive inside repeating time windows. A scheduler raises a per-module command-valid line, and the block answers in the same cycle with a grant when the module still has budget. Every granted command, whether an activation, a read or a write to any rank of that module, counts against one shared counter for that module. The scheduler gives the block one valid line per module, so all ranks of that module are counted together.

Two independent budgets apply at once. The thermal budget is set for each window whose length in clocks is a programmed 11-bit field shifted left by three. Its cap follows the module's thermal level (none, mid, high, critical, each with its own 8-bit cap), and an external hot-memory input adds a second 8-bit cap on the same counter. The power budget uses a fixed one-microsecond window, with a clock count given as a parameter, and a 12-bit cap per module that can be enabled per module. A policy bit decides whether throttling also asks for the module's clock enable to be dropped.

Top module: `dimm_activity_throttle`

## Requirements
- R1: While reset is high and in the cycle after it, every clock-enable-drop request is 0. Reset also restarts both window timers and clears all counters.
- R2: The thermal window lasts `cfg_win_len * 8` clocks. It starts in the first cycle after reset and repeats back to back. Each module's thermal counter is zero at the start of every thermal window.
- R3: A cycle counts against a module only when that module is granted. Cycles without a valid command consume no budget.
- R4: With throttling enabled, the thermal cap of a module comes from its 2-bit level code: 0 means no cap, 1 uses the mid cap, 2 uses the high cap and 3 uses the critical cap. A cap of N lets exactly N grants through per window, so a cap of 0 blocks every command.
- R5: With level 0, or with `cfg_bw_thrt_en` at 0, the thermal level places no cap, and a module that is valid in every cycle is granted in every cycle.
- R6: While `ext_hot` is 1, each module is also limited to `cfg_ext_lim` grants per thermal window, whatever its level and whatever `cfg_bw_thrt_en` holds.
- R7: With its power enable set, a module gets at most its 12-bit power cap of grants per power window of CLK_PER_US clocks. With the enable clear, power places no cap.
- R8: A command is granted only when the module's counts are below every active cap at the same time: thermal level, external and power.
- R9: The clock-enable-drop request of a module is registered. One cycle after the inputs, it equals NOT `cfg_allow_isoch` AND (`ext_hot` OR (`cfg_bw_thrt_en` AND level is not 0)).
- R10: The budgets of different modules are independent. Grants to one module never change another module's grants.
- R11: Counters keep counting while no cap is active. If a cap becomes active part-way through a window, the grants already given in that window count against it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | NUM_MODULES | Per-module command request |
| cmd_grant | output | NUM_MODULES | Per-module grant, same cycle as the request |
| therm_level | input | 2*NUM_MODULES | Per-module thermal level code, 2 bits each |
| ext_hot | input | 1 | External hot-memory indication |
| cfg_bw_thrt_en | input | 1 | Enables thermal-level throttling |
| cfg_allow_isoch | input | 1 | 1 keeps clock enable up during throttling |
| cfg_win_len | input | 11 | Thermal window length before the shift by 3 |
| cfg_lim_mid | input | 8*NUM_MODULES | Per-module cap at level 1 |
| cfg_lim_hi | input | 8*NUM_MODULES | Per-module cap at level 2 |
| cfg_lim_crit | input | 8*NUM_MODULES | Per-module cap at level 3 |
| cfg_ext_lim | input | 8 | Cap while ext_hot is asserted |
| cfg_pwr_en | input | NUM_MODULES | Per-module power throttle enable |
| cfg_pwr_lim | input | 12*NUM_MODULES | Per-module cap per power window |
| cke_drop_req | output | NUM_MODULES | Registered request to drop clock enable |

## Verification
The bench counts grants over whole windows. A window that is off by one clock, or that forgets the shift by three, shows up as a wrong total over several windows. Modules at different levels run side by side with a critical cap of zero, so a mixed-up level decode or counters that leak between modules change the totals. The bench stacks the external, thermal and power caps together, so a design that obeys only one of them grants too many commands. It raises a cap part-way through a window that is already spent, so a design that counts only while throttled would wrongly grant again. Cycles without a request are mixed in to catch designs that charge idle cycles.

// File: rtl/dtl_pkg.sv
package dtl_pkg;
  typedef enum logic [1:0] {
    LVL_COOL = 2'd0,
    LVL_MID  = 2'd1,
    LVL_HI   = 2'd2,
    LVL_CRIT = 2'd3
  } therm_lvl_e;
endpackage

// File: rtl/dtl_window_timer.sv
// Free-running window timer; wrap is high in the last cycle of each window.
module dtl_window_timer #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] len,
  output logic             wrap
);
  logic [CNT_W-1:0] tick_q;
  logic [CNT_W:0]   next_pos;

  always_comb begin
    next_pos = {1'b0, tick_q} + 1'b1;
    wrap     = (next_pos >= {1'b0, len});
  end

  always_ff @(posedge clk) begin
    if (rst || wrap) tick_q <= '0;
    else             tick_q <= tick_q + 1'b1;
  end
endmodule

// File: rtl/dtl_sat_counter.sv
// Saturating activity counter, cleared at a window boundary.
module dtl_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)             cnt <= '0;
    else if (inc && cnt != '1)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dtl_module_budget.sv
// Per-module budget: thermal/external counter, power counter, grant logic.
module dtl_module_budget
  import dtl_pkg::*;
#(
  parameter int LIM_W = 8,
  parameter int PWR_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  therm_lvl_e       level,
  input  logic             ext_hot,
  input  logic             bw_en,
  input  logic             allow_isoch,
  input  logic [LIM_W-1:0] lim_mid,
  input  logic [LIM_W-1:0] lim_hi,
  input  logic [LIM_W-1:0] lim_crit,
  input  logic [LIM_W-1:0] ext_lim,
  input  logic             pwr_en,
  input  logic [PWR_W-1:0] pwr_lim,
  input  logic             therm_wrap,
  input  logic             pwr_wrap,
  output logic             grant,
  output logic             cke_drop
);
  logic [LIM_W-1:0] therm_cnt;
  logic [PWR_W-1:0] pwr_cnt;
  logic [LIM_W-1:0] therm_cap;
  logic             therm_on;
  logic             ok_therm, ok_ext, ok_pwr;

  always_comb begin
    unique case (level)
      LVL_MID:  therm_cap = lim_mid;
      LVL_HI:   therm_cap = lim_hi;
      LVL_CRIT: therm_cap = lim_crit;
      default:  therm_cap = '1;
    endcase
    therm_on = bw_en && (level != LVL_COOL);
    ok_therm = !therm_on || (therm_cnt < therm_cap);
    ok_ext   = !ext_hot  || (therm_cnt < ext_lim);
    ok_pwr   = !pwr_en   || (pwr_cnt < pwr_lim);
    grant    = valid && ok_therm && ok_ext && ok_pwr;
  end

  dtl_sat_counter #(.W(LIM_W)) u_therm_cnt (
    .clk(clk), .rst(rst), .clr(therm_wrap), .inc(grant), .cnt(therm_cnt)
  );

  dtl_sat_counter #(.W(PWR_W)) u_pwr_cnt (
    .clk(clk), .rst(rst), .clr(pwr_wrap), .inc(grant), .cnt(pwr_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) cke_drop <= 1'b0;
    else     cke_drop <= !allow_isoch && (ext_hot || therm_on);
  end
endmodule

// File: rtl/dimm_activity_throttle.sv
module dimm_activity_throttle
  import dtl_pkg::*;
#(
  parameter int NUM_MODULES = 3,
  parameter int CLK_PER_US  = 100,
  parameter int WIN_FIELD_W = 11,
  parameter int WIN_SHIFT   = 3,
  parameter int LIM_W       = 8,
  parameter int PWR_W       = 12
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_MODULES-1:0]       cmd_valid,
  output logic [NUM_MODULES-1:0]       cmd_grant,
  input  logic [2*NUM_MODULES-1:0]     therm_level,
  input  logic                         ext_hot,
  input  logic                         cfg_bw_thrt_en,
  input  logic                         cfg_allow_isoch,
  input  logic [WIN_FIELD_W-1:0]       cfg_win_len,
  input  logic [LIM_W*NUM_MODULES-1:0] cfg_lim_mid,
  input  logic [LIM_W*NUM_MODULES-1:0] cfg_lim_hi,
  input  logic [LIM_W*NUM_MODULES-1:0] cfg_lim_crit,
  input  logic [LIM_W-1:0]             cfg_ext_lim,
  input  logic [NUM_MODULES-1:0]       cfg_pwr_en,
  input  logic [PWR_W*NUM_MODULES-1:0] cfg_pwr_lim,
  output logic [NUM_MODULES-1:0]       cke_drop_req
);
  localparam int TWIN_W = WIN_FIELD_W + WIN_SHIFT;
  localparam int US_W   = $clog2(CLK_PER_US + 1);
  localparam logic [US_W-1:0] US_LEN = US_W'(CLK_PER_US);

  logic [TWIN_W-1:0] therm_len;
  logic              therm_wrap, pwr_wrap;

  assign therm_len = {cfg_win_len, {WIN_SHIFT{1'b0}}};

  dtl_window_timer #(.CNT_W(TWIN_W)) u_therm_timer (
    .clk(clk), .rst(rst), .len(therm_len), .wrap(therm_wrap)
  );

  dtl_window_timer #(.CNT_W(US_W)) u_pwr_timer (
    .clk(clk), .rst(rst), .len(US_LEN), .wrap(pwr_wrap)
  );

  for (genvar m = 0; m < NUM_MODULES; m++) begin : g_mod
    dtl_module_budget #(.LIM_W(LIM_W), .PWR_W(PWR_W)) u_budget (
      .clk        (clk),
      .rst        (rst),
      .valid      (cmd_valid[m]),
      .level      (therm_lvl_e'(therm_level[2*m +: 2])),
      .ext_hot    (ext_hot),
      .bw_en      (cfg_bw_thrt_en),
      .allow_isoch(cfg_allow_isoch),
      .lim_mid    (cfg_lim_mid[LIM_W*m +: LIM_W]),
      .lim_hi     (cfg_lim_hi[LIM_W*m +: LIM_W]),
      .lim_crit   (cfg_lim_crit[LIM_W*m +: LIM_W]),
      .ext_lim    (cfg_ext_lim),
      .pwr_en     (cfg_pwr_en[m]),
      .pwr_lim    (cfg_pwr_lim[PWR_W*m +: PWR_W]),
      .therm_wrap (therm_wrap),
      .pwr_wrap   (pwr_wrap),
      .grant      (cmd_grant[m]),
      .cke_drop   (cke_drop_req[m])
    );
  end
endmodule

// File: rtl/dimm_activity_throttle_chk.sv
module dimm_activity_throttle_chk #(
  parameter int NUM_MODULES = 3,
  parameter int LIM_W       = 8,
  parameter int PWR_W       = 12
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NUM_MODULES-1:0]       cmd_valid,
  input logic [NUM_MODULES-1:0]       cmd_grant,
  input logic [2*NUM_MODULES-1:0]     therm_level,
  input logic                         ext_hot,
  input logic                         cfg_bw_thrt_en,
  input logic                         cfg_allow_isoch,
  input logic [LIM_W*NUM_MODULES-1:0] cfg_lim_crit,
  input logic [LIM_W-1:0]             cfg_ext_lim,
  input logic [NUM_MODULES-1:0]       cfg_pwr_en,
  input logic [PWR_W*NUM_MODULES-1:0] cfg_pwr_lim,
  input logic [NUM_MODULES-1:0]       cke_drop_req
);
  // R1: drop request clear right after a reset cycle
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (cke_drop_req == '0));

  for (genvar m = 0; m < NUM_MODULES; m++) begin : g_chk
    // R8: no grant without a request
    a_r8_grant_needs_valid: assert property (@(posedge clk) disable iff (rst)
      cmd_grant[m] |-> cmd_valid[m]);

    // R4: critical level with a zero cap blocks everything
    a_r4_crit_zero_blocks: assert property (@(posedge clk) disable iff (rst)
      (cfg_bw_thrt_en && therm_level[2*m +: 2] == 2'd3 &&
       cfg_lim_crit[LIM_W*m +: LIM_W] == '0) |-> !cmd_grant[m]);

    // R6: external cap of zero blocks everything
    a_r6_ext_zero_blocks: assert property (@(posedge clk) disable iff (rst)
      (ext_hot && cfg_ext_lim == '0) |-> !cmd_grant[m]);

    // R7: enabled power cap of zero blocks everything
    a_r7_pwr_zero_blocks: assert property (@(posedge clk) disable iff (rst)
      (cfg_pwr_en[m] && cfg_pwr_lim[PWR_W*m +: PWR_W] == '0) |-> !cmd_grant[m]);

    // R9: drop request follows policy one cycle later
    a_r9_cke_policy: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (cke_drop_req[m] == $past(!cfg_allow_isoch &&
        (ext_hot || (cfg_bw_thrt_en && therm_level[2*m +: 2] != 2'd0)))));
  end
endmodule

bind dimm_activity_throttle dimm_activity_throttle_chk #(
  .NUM_MODULES(NUM_MODULES), .LIM_W(LIM_W), .PWR_W(PWR_W)
) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_grant(cmd_grant),
  .therm_level(therm_level), .ext_hot(ext_hot),
  .cfg_bw_thrt_en(cfg_bw_thrt_en), .cfg_allow_isoch(cfg_allow_isoch),
  .cfg_lim_crit(cfg_lim_crit), .cfg_ext_lim(cfg_ext_lim),
  .cfg_pwr_en(cfg_pwr_en), .cfg_pwr_lim(cfg_pwr_lim),
  .cke_drop_req(cke_drop_req)
);

// File: tb/dimm_activity_throttle_bench.sv
module dimm_activity_throttle_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic [NM-1:0] cmd_valid;
  logic [NM-1:0] cmd_grant;
  logic [2*NM-1:0] therm_level;
  logic          ext_hot;
  logic          cfg_bw_thrt_en;
  logic          cfg_allow_isoch;
  logic [10:0]   cfg_win_len;
  logic [8*NM-1:0] cfg_lim_mid, cfg_lim_hi, cfg_lim_crit;
  logic [7:0]    cfg_ext_lim;
  logic [NM-1:0] cfg_pwr_en;
  logic [12*NM-1:0] cfg_pwr_lim;
  logic [NM-1:0] cke_drop_req;

  int n_checks = 0;
  int n_fail   = 0;
  int gcnt [NM];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dimm_activity_throttle u_dimm_activity_throttle (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_grant(cmd_grant),
    .therm_level(therm_level), .ext_hot(ext_hot),
    .cfg_bw_thrt_en(cfg_bw_thrt_en), .cfg_allow_isoch(cfg_allow_isoch),
    .cfg_win_len(cfg_win_len), .cfg_lim_mid(cfg_lim_mid),
    .cfg_lim_hi(cfg_lim_hi), .cfg_lim_crit(cfg_lim_crit),
    .cfg_ext_lim(cfg_ext_lim), .cfg_pwr_en(cfg_pwr_en),
    .cfg_pwr_lim(cfg_pwr_lim), .cke_drop_req(cke_drop_req)
  );

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_defaults();
    therm_level = '0; ext_hot = 1'b0; cfg_bw_thrt_en = 1'b1;
    cfg_allow_isoch = 1'b0; cfg_win_len = 11'd4;
    cfg_lim_mid = {NM{8'hFF}}; cfg_lim_hi = {NM{8'h0F}}; cfg_lim_crit = '0;
    cfg_ext_lim = 8'd0; cfg_pwr_en = '1; cfg_pwr_lim = {NM{12'hFFF}};
    cmd_valid = '0;
  endtask

  // Leaves the bench at the negedge where window cycle 0 begins.
  task automatic do_reset();
    @(negedge clk); rst = 1'b1; cmd_valid = '0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  // Runs n cycles starting at the current negedge; alt=1 requests every other cycle.
  task automatic run(int n, logic [NM-1:0] mask, bit alt);
    for (int i = 0; i < NM; i++) gcnt[i] = 0;
    for (int c = 0; c < n; c++) begin
      cmd_valid = (alt && (c % 2 == 1)) ? '0 : mask;
      #1;
      for (int i = 0; i < NM; i++) if (cmd_grant[i]) gcnt[i]++;
      @(negedge clk);
    end
    cmd_valid = '0;
  endtask

  task automatic t_reset();
    set_defaults(); do_reset();
    #1; check("R1 cke after reset", int'(cke_drop_req), 0);
    run(32, '1, 1'b0);
    for (int i = 0; i < NM; i++) check("R5 cool unlimited", gcnt[i], 32);
  endtask

  task automatic t_levels();
    set_defaults();
    cfg_lim_mid[7:0] = 8'd5; cfg_lim_hi[15:8] = 8'd3;
    therm_level = {2'd3, 2'd2, 2'd1};
    do_reset(); run(64, '1, 1'b0);
    check("R4 mid cap over two windows", gcnt[0], 10);
    check("R4 high cap over two windows", gcnt[1], 6);
    check("R4 crit zero cap", gcnt[2], 0);
  endtask

  task automatic t_window();
    set_defaults(); cfg_win_len = 11'd2;
    cfg_lim_mid = {NM{8'd4}}; therm_level = {2'd0, 2'd0, 2'd1};
    do_reset(); run(48, 3'b011, 1'b0);
    check("R2 window of 16 clocks", gcnt[0], 12);
    check("R10 neighbour unaffected", gcnt[1], 48);
    check("R10 idle module no grant", gcnt[2], 0);
  endtask

  task automatic t_bw_off();
    set_defaults(); cfg_bw_thrt_en = 1'b0; therm_level = '1;
    do_reset(); run(32, '1, 1'b0);
    check("R5 throttle disabled", gcnt[2], 32);
  endtask

  task automatic t_ext();
    set_defaults(); cfg_bw_thrt_en = 1'b0; ext_hot = 1'b1; cfg_ext_lim = 8'd2;
    do_reset(); run(32, '1, 1'b0);
    check("R6 external cap", gcnt[0], 2);
    set_defaults(); ext_hot = 1'b1; cfg_ext_lim = 8'd6;
    cfg_lim_mid[7:0] = 8'd3; therm_level = {2'd0, 2'd0, 2'd1};
    do_reset(); run(32, '1, 1'b0);
    check("R8 lower of thermal and external", gcnt[0], 3);
    check("R6 external only on cool module", gcnt[1], 6);
  endtask

  task automatic t_power();
    set_defaults(); cfg_win_len = 11'h3FF;
    cfg_pwr_lim = {12'd0, 12'd0, 12'd7}; cfg_pwr_en = 3'b101;
    do_reset(); run(200, '1, 1'b0);
    check("R7 power cap over two windows", gcnt[0], 14);
    check("R7 power disabled", gcnt[1], 200);
    check("R7 power cap zero", gcnt[2], 0);
  endtask

  task automatic t_combo();
    set_defaults(); cfg_lim_mid[7:0] = 8'd5; therm_level = 6'd1;
    cfg_pwr_lim[11:0] = 12'd3;
    do_reset(); run(32, 3'b001, 1'b0);
    check("R8 power tighter than thermal", gcnt[0], 3);
  endtask

  task automatic t_sparse();
    set_defaults(); cfg_lim_mid = {8'd0, 8'd20, 8'd5}; therm_level = {2'd0, 2'd1, 2'd1};
    do_reset(); run(32, 3'b011, 1'b1);
    check("R3 sparse requests to cap", gcnt[0], 5);
    check("R3 idle cycles not charged", gcnt[1], 16);
  endtask

  task automatic t_late_cap();
    set_defaults();
    do_reset(); run(20, 3'b001, 1'b0);
    check("R11 counting while uncapped", gcnt[0], 20);
    cfg_lim_mid[7:0] = 8'd10; therm_level = 6'd1;
    run(12, 3'b001, 1'b0);
    check("R11 spent budget blocks late cap", gcnt[0], 0);
    run(32, 3'b001, 1'b0);
    check("R11 next window fresh", gcnt[0], 10);
  endtask

  task automatic t_cke();
    set_defaults(); do_reset();
    therm_level = 6'd1;
    @(negedge clk); #1;
    check("R9 drop on throttled module", int'(cke_drop_req), 1);
    cfg_allow_isoch = 1'b1;
    @(negedge clk); #1;
    check("R9 isoch allowed keeps cke", int'(cke_drop_req), 0);
    cfg_allow_isoch = 1'b0; ext_hot = 1'b1; therm_level = '0;
    @(negedge clk); #1;
    check("R9 external hot drops all", int'(cke_drop_req), 7);
    rst = 1'b1;
    @(negedge clk); #1;
    check("R1 reset clears drop", int'(cke_drop_req), 0);
    rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1;
    set_defaults();
    t_reset();
    t_levels();
    t_window();
    t_bw_off();
    t_ext();
    t_power();
    t_combo();
    t_sparse();
    t_late_cap();
    t_cke();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule